// File: doc/BRIEF.md
# L1 Exit Propagation Controller

This block sits beside the link layers of a small switch partition and decides, port by port, when a link must begin leaving the L1 low-power state. The partition has one upstream port, always at index 0, and `NUM_DN` downstream ports at indices 1 to `NUM_DN`. Each port reports four things: a 2-bit mode code, whether a TLP is waiting to go out, whether its link is currently in L1, and whether it has itself begun an L1 exit. For each port the block returns a one-cycle request to begin exiting L1.

Which events wake a port depends on its mode. A downstream-switch-mode port wakes for its own traffic and when the upstream port starts an exit. A port in either NT mode wakes only for its own traffic. The upstream port wakes for its own traffic and when any downstream-switch-mode port starts an exit. The exit flags are registered on their way across the partition, so a wake crosses in a fixed two clock cycles. An elaboration check refuses a clock period for which those two cycles would exceed a quarter of the 1 µs bound.

Each port has its own small state machine with four states. `ST_AWAKE`: the link is not in L1. `ST_DOZE`: in L1 and armed. `ST_WAKE`: the one cycle in which the request is driven. `ST_SPENT`: in L1 with the request already issued. The transitions are as follows. AWAKE goes to WAKE when the link is in L1 and the trigger rises, and goes to DOZE when the link is in L1 without a rise. DOZE goes to AWAKE when the link leaves L1, and goes to WAKE on a trigger rise. WAKE goes to SPENT if the link is still in L1, and otherwise goes to AWAKE. SPENT goes to AWAKE when the link leaves L1.

Top module: `l1_exit_prop`

## Requirements
- R1: While reset is asserted, and after it until a trigger rises on a port that is in L1, `exit_req` is all zeros.
- R2: For a port with mode 2'b00 (downstream switch), a rising `tlp_pend` sampled at a clock edge while `in_l1` is high raises that port's `exit_req` right after that edge.
- R3: For a port with mode 2'b00, a rising `exit_started[0]` sampled at edge k raises that port's `exit_req` right after edge k+1, provided port 0 has mode 2'b11 and the port is in L1.
- R4: A port with mode 2'b01 (NT) or 2'b10 (NT with DMA) is raised only by its own `tlp_pend`. Exit starts on any other port never raise its `exit_req`.
- R5: Port 0 with mode 2'b11 (upstream) raises `exit_req[0]` right after an edge at which its own `tlp_pend` is seen rising while it is in L1.
- R6: A rising exit start on any port with mode 2'b00, sampled at edge k, raises `exit_req[0]` right after edge k+1. Exit starts on ports in mode 2'b01 or 2'b10 do not.
- R7: No request is issued for a port whose `in_l1` was low at the edge that would have issued it.
- R8: Each request lasts exactly one cycle. At most one request is issued per L1 residence. The port re-arms only after `in_l1` has been seen low for at least one edge.
- R9: Requests follow trigger rises, not trigger levels. A port that enters L1 with its trigger already high gets no request until the trigger falls and rises again.
- R10: The cross-port wake path is two clock cycles. Elaboration fails if two periods of `CLK_PERIOD_NS` exceed a quarter of `EXIT_BOUND_NS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_mode | input | 2*(NUM_DN+1) | Mode code of port i in bits [2i+1:2i]: 00 downstream switch, 01 NT, 10 NT with DMA, 11 upstream |
| tlp_pend | input | NUM_DN+1 | A TLP is scheduled for transmission on port i |
| in_l1 | input | NUM_DN+1 | Link of port i is in L1 |
| exit_started | input | NUM_DN+1 | Port i has begun an L1 exit |
| exit_req | output | NUM_DN+1 | One-cycle request for port i to begin an L1 exit |

## Verification
The assertions assume that port 0 always carries mode 2'b11. They also assume that no downstream index carries that code, because the cross-port cause checks count only port 0 as the upstream source. The cause checks further assume that inputs change only between clock edges, since they look back one or two cycles to find the rise that explains a request. The bench fixes port 0 at 2'b11 and draws each downstream mode from the three downstream codes only. It drives every input just after the falling edge, in both the directed and the random phases.

// File: rtl/l1x_pkg.sv
package l1x_pkg;

    typedef enum logic [1:0] {
        MODE_DSP    = 2'b00,
        MODE_NT     = 2'b01,
        MODE_NT_DMA = 2'b10,
        MODE_USP    = 2'b11
    } port_mode_e;

    typedef enum logic [1:0] {
        ST_AWAKE,
        ST_DOZE,
        ST_WAKE,
        ST_SPENT
    } wake_state_e;

    // Registered stages between one port's exit start and a linked port's request.
    localparam int PROP_CYCLES = 2;

endpackage

// File: rtl/l1x_link_sense.sv
module l1x_link_sense
    import l1x_pkg::*;
#(
    parameter int NUM_PORTS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2*NUM_PORTS-1:0] port_mode,
    input  logic [NUM_PORTS-1:0]   exit_started,
    output logic                   up_exit_q,
    output logic                   dn_exit_q
);

    logic dn_any;
    logic up_now;

    // Upstream exit counts only when index 0 really is the upstream port.
    assign up_now = exit_started[0] && (port_mode_e'(port_mode[1:0]) == MODE_USP);

    always_comb begin
        dn_any = 1'b0;
        for (int i = 1; i < NUM_PORTS; i++) begin
            if (exit_started[i] && (port_mode_e'(port_mode[2*i +: 2]) == MODE_DSP)) begin
                dn_any = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            up_exit_q <= 1'b0;
            dn_exit_q <= 1'b0;
        end else begin
            up_exit_q <= up_now;
            dn_exit_q <= dn_any;
        end
    end

endmodule

// File: rtl/l1x_trigger.sv
module l1x_trigger
    import l1x_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       tlp_pend,
    input  logic       up_exit_q,
    input  logic       dn_exit_q,
    output logic       trig
);

    always_comb begin
        unique case (port_mode_e'(mode))
            MODE_DSP:    trig = tlp_pend | up_exit_q;
            MODE_NT:     trig = tlp_pend;
            MODE_NT_DMA: trig = tlp_pend;
            MODE_USP:    trig = tlp_pend | dn_exit_q;
        endcase
    end

endmodule

// File: rtl/l1x_port_fsm.sv
module l1x_port_fsm
    import l1x_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_l1,
    input  logic trig,
    output logic exit_req
);

    wake_state_e state_q, state_d;
    logic        trig_q;
    logic        trig_rise;

    assign trig_rise = trig & ~trig_q;

    // State register and trigger history.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_AWAKE;
            trig_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            trig_q  <= trig;
        end
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_AWAKE: begin
                if (in_l1) begin
                    state_d = trig_rise ? ST_WAKE : ST_DOZE;
                end
            end
            ST_DOZE: begin
                if (!in_l1) begin
                    state_d = ST_AWAKE;
                end else if (trig_rise) begin
                    state_d = ST_WAKE;
                end
            end
            ST_WAKE: begin
                state_d = in_l1 ? ST_SPENT : ST_AWAKE;
            end
            ST_SPENT: begin
                if (!in_l1) begin
                    state_d = ST_AWAKE;
                end
            end
        endcase
    end

    // Outputs.
    always_comb begin
        exit_req = (state_q == ST_WAKE);
    end

endmodule

// File: rtl/l1_exit_prop.sv
module l1_exit_prop
    import l1x_pkg::*;
#(
    parameter int NUM_DN        = 3,
    parameter int CLK_PERIOD_NS = 20,
    parameter int EXIT_BOUND_NS = 1000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2*(NUM_DN+1)-1:0] port_mode,
    input  logic [NUM_DN:0]         tlp_pend,
    input  logic [NUM_DN:0]         in_l1,
    input  logic [NUM_DN:0]         exit_started,
    output logic [NUM_DN:0]         exit_req
);

    localparam int NUM_PORTS = NUM_DN + 1;
    localparam int PROP_NS   = PROP_CYCLES * CLK_PERIOD_NS;

    // R10: the registered wake path must sit well inside the exit bound.
    if (PROP_NS * 4 > EXIT_BOUND_NS) begin : g_bound_violation
        $error("cross-port wake path of %0d ns exceeds a quarter of %0d ns", PROP_NS, EXIT_BOUND_NS);
    end

    logic                 up_exit_q;
    logic                 dn_exit_q;
    logic [NUM_PORTS-1:0] trig;

    l1x_link_sense #(
        .NUM_PORTS (NUM_PORTS)
    ) u_sense (
        .clk          (clk),
        .rst_n        (rst_n),
        .port_mode    (port_mode),
        .exit_started (exit_started),
        .up_exit_q    (up_exit_q),
        .dn_exit_q    (dn_exit_q)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        l1x_trigger u_trig (
            .mode      (port_mode[2*p +: 2]),
            .tlp_pend  (tlp_pend[p]),
            .up_exit_q (up_exit_q),
            .dn_exit_q (dn_exit_q),
            .trig      (trig[p])
        );

        l1x_port_fsm u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_l1    (in_l1[p]),
            .trig     (trig[p]),
            .exit_req (exit_req[p])
        );
    end

endmodule

// File: rtl/l1_exit_prop_chk.sv
module l1_exit_prop_chk #(
    parameter int NUM_DN = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [2*(NUM_DN+1)-1:0] port_mode,
    input logic [NUM_DN:0]         tlp_pend,
    input logic [NUM_DN:0]         in_l1,
    input logic [NUM_DN:0]         exit_started,
    input logic [NUM_DN:0]         exit_req
);

    p_port0_usp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        port_mode[1:0] == 2'b11);

    p_usp_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        exit_req[0] |-> ($past(tlp_pend[0]) || $past(|exit_started[NUM_DN:1], 2)));

    for (genvar i = 0; i <= NUM_DN; i++) begin : g_chk
        p_req_needs_l1_r7: assert property (@(posedge clk) disable iff (!rst_n)
            exit_req[i] |-> $past(in_l1[i]));

        p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
            exit_req[i] |=> !exit_req[i]);

        if (i > 0) begin : g_dn
            p_nt_own_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (exit_req[i] && ($past(port_mode[2*i +: 2]) inside {2'b01, 2'b10}))
                |-> $past(tlp_pend[i]));

            p_dsp_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (exit_req[i] && ($past(port_mode[2*i +: 2]) == 2'b00))
                |-> ($past(tlp_pend[i]) || $past(exit_started[0], 2)));
        end
    end

endmodule

bind l1_exit_prop l1_exit_prop_chk #(.NUM_DN(NUM_DN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .port_mode    (port_mode),
    .tlp_pend     (tlp_pend),
    .in_l1        (in_l1),
    .exit_started (exit_started),
    .exit_req     (exit_req)
);

// File: tb/l1_exit_prop_test.sv
`timescale 1ns/1ps
module l1_exit_prop_test;

    localparam int ND = 3;
    localparam int NP = ND + 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [2*NP-1:0] port_mode = 8'b10_01_00_11;
    logic [NP-1:0]   tlp_pend = '0;
    logic [NP-1:0]   in_l1 = '0;
    logic [NP-1:0]   exit_started = '0;
    logic [NP-1:0]   exit_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench model state: 0 awake, 1 doze, 2 wake, 3 spent.
    int          m_st [NP];
    bit          m_tq [NP];
    bit          m_up;
    bit          m_dn;
    logic [NP-1:0] exp_req;

    always #10 clk = ~clk;

    l1_exit_prop #(.NUM_DN(ND), .CLK_PERIOD_NS(20), .EXIT_BOUND_NS(1000)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .port_mode    (port_mode),
        .tlp_pend     (tlp_pend),
        .in_l1        (in_l1),
        .exit_started (exit_started),
        .exit_req     (exit_req)
    );

    function automatic bit trig_of(int p);
        logic [1:0] m = port_mode[2*p +: 2];
        case (m)
            2'b00:   return tlp_pend[p] | m_up;
            2'b11:   return tlp_pend[p] | m_dn;
            default: return tlp_pend[p];
        endcase
    endfunction

    task automatic model_reset();
        for (int p = 0; p < NP; p++) begin
            m_st[p] = 0;
            m_tq[p] = 1'b0;
        end
        m_up = 1'b0;
        m_dn = 1'b0;
        exp_req = '0;
    endtask

    task automatic model_step();
        bit nt [NP];
        bit nd;
        for (int p = 0; p < NP; p++) begin
            bit t    = trig_of(p);
            bit rise = t & ~m_tq[p];
            int nx   = m_st[p];
            case (m_st[p])
                0: if (in_l1[p]) nx = rise ? 2 : 1;
                1: if (!in_l1[p]) nx = 0; else if (rise) nx = 2;
                2: nx = in_l1[p] ? 3 : 0;
                default: if (!in_l1[p]) nx = 0;
            endcase
            m_st[p]    = nx;
            nt[p]      = t;
            exp_req[p] = (nx == 2);
        end
        nd = 1'b0;
        for (int p = 1; p < NP; p++) begin
            if (exit_started[p] && port_mode[2*p +: 2] == 2'b00) nd = 1'b1;
        end
        for (int p = 0; p < NP; p++) m_tq[p] = nt[p];
        m_up = exit_started[0] && (port_mode[1:0] == 2'b11);
        m_dn = nd;
    endtask

    task automatic check_val(input string tag, input logic [NP-1:0] want);
        checks++;
        if (exit_req !== want) begin
            fails++;
            $display("FAIL %s: exit_req=%b expected %b", tag, exit_req, want);
        end
    endtask

    // Apply inputs, advance one edge, compare with the model at the falling edge.
    task automatic step(input string tag, input logic [NP-1:0] t,
                        input logic [NP-1:0] l, input logic [NP-1:0] e);
        tlp_pend = t;
        in_l1 = l;
        exit_started = e;
        model_step();
        @(negedge clk);
        check_val(tag, exp_req);
    endtask

    task automatic rearm();
        step("rearm R8", 4'b0000, 4'b0000, 4'b0000);
        step("rearm R8", 4'b0000, 4'b1111, 4'b0000);
    endtask

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(negedge clk);
        check_val("R1 during reset", 4'b0000);
        rst_n = 1'b1;

        step("R1 after reset", 4'b0000, 4'b1111, 4'b0000);
        check_val("R1 idle hand", 4'b0000);

        // Downstream port 1 own traffic.
        step("R2 own tlp", 4'b0010, 4'b1111, 4'b0000);
        check_val("R2 hand", 4'b0010);
        step("R8 pulse ends", 4'b0010, 4'b1111, 4'b0000);
        check_val("R8 hand single", 4'b0000);
        step("R8 spent", 4'b0000, 4'b1111, 4'b0000);
        step("R8 second rise ignored", 4'b0010, 4'b1111, 4'b0000);
        check_val("R8 hand spent", 4'b0000);
        step("R8 leave", 4'b0000, 4'b1101, 4'b0000);
        step("R8 reenter", 4'b0000, 4'b1111, 4'b0000);
        step("R8 rearmed", 4'b0010, 4'b1111, 4'b0000);
        check_val("R8 hand rearmed", 4'b0010);

        // Upstream exit carried to the downstream-switch port only.
        rearm();
        step("R3 edge k", 4'b0000, 4'b1111, 4'b0001);
        check_val("R3 hand k", 4'b0000);
        step("R3 R10 edge k+1", 4'b0000, 4'b1111, 4'b0001);
        check_val("R3 R10 R4 hand", 4'b0010);
        step("R4 nt unaffected", 4'b0000, 4'b1111, 4'b0001);
        check_val("R4 hand", 4'b0000);

        // Downstream exits carried to the upstream port.
        rearm();
        step("R6 nt exit", 4'b0000, 4'b1111, 4'b0100);
        step("R6 nt exit ignored", 4'b0000, 4'b1111, 4'b0100);
        check_val("R6 hand nt", 4'b0000);
        step("R6 dsp exit k", 4'b0000, 4'b1111, 4'b0110);
        check_val("R6 hand k", 4'b0000);
        step("R6 dsp exit k+1", 4'b0000, 4'b1111, 4'b0110);
        check_val("R6 hand k+1", 4'b0001);

        rearm();
        step("R5 usp own tlp", 4'b0001, 4'b1111, 4'b0000);
        check_val("R5 hand", 4'b0001);
        rearm();
        step("R4 nt own tlp", 4'b1100, 4'b1111, 4'b0000);
        check_val("R4 hand own", 4'b1100);

        // Not in L1, then entry with triggers already high.
        step("R7 not in l1", 4'b1111, 4'b0000, 4'b0001);
        step("R7 not in l1", 4'b1111, 4'b0000, 4'b0001);
        check_val("R7 hand", 4'b0000);
        step("R9 enter high", 4'b1111, 4'b1111, 4'b0001);
        check_val("R9 hand", 4'b0000);
        step("R9 still high", 4'b1111, 4'b1111, 4'b0001);
        check_val("R9 hand hold", 4'b0000);

        // Random phase.
        for (int c = 0; c < 800; c++) begin
            logic [NP-1:0] t = tlp_pend;
            logic [NP-1:0] l = in_l1;
            logic [NP-1:0] e = exit_started;
            if (c % 40 == 0) begin
                for (int p = 1; p < NP; p++) port_mode[2*p +: 2] = 2'($urandom % 3);
            end
            for (int p = 0; p < NP; p++) begin
                if ($urandom % 8 == 0) l[p] = ~l[p];
                if ($urandom % 4 == 0) t[p] = ~t[p];
                if ($urandom % 6 == 0) e[p] = ~e[p];
            end
            step("random R2 R3 R4 R5 R6 R7 R8 R9", t, l, e);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1: run did not end, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule